// File: doc/BRIEF.md
# External PCI Bus Bring-Up Sequencer

This block powers up an external PCI bus in a fixed order once the host core has left reset. A single start pulse begins the sequence. The block first turns on the drivers for the bus reset line and the bus clock, with the clock still stopped and the bus held in reset. It then starts the bus clock, holds reset for a programmed minimum time, and releases reset. After that it hands bus arbitration to the internal arbiter and waits for the arbiter and the bus to settle. Only then does it raise a ready flag.

Every wait is counted in core clock cycles. The count comes from an input that gives the number of core cycles per microsecond. The block samples that input when it accepts the start pulse and uses the sampled value for the whole run. The microsecond lengths of the three waits are parameters. By default, reset is held for 150 µs after the clock starts, the arbiter is given 1 µs, and the bus then settles for 10 ms. One down-counter is reused for all three waits. Each output, once raised, stays high until the block is reset. Software that does the window setup and configuration accesses polls the ready flag before it goes on.

Top module: `pcib_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, all six outputs are low until a start pulse is accepted. Asserting `rst_n` in the middle of a sequence drops every output at once.
- R2: A high `start_i` sampled at a clock edge while the block is idle sets `pci_rst_oe_o` and `pci_clk_oe_o` after that edge. At the same time `pci_clk_en_o` and `pci_rst_release_o` stay low.
- R3: `pci_clk_en_o` rises exactly one cycle after the output enables, while `pci_rst_release_o` is still low.
- R4: `pci_rst_release_o` rises exactly HOLD_US × N cycles after `pci_clk_en_o` rises. N is the captured cycles-per-microsecond value.
- R5: `arb_internal_o` rises exactly one cycle after `pci_rst_release_o`.
- R6: `bus_ready_o` rises exactly (ARB_US + SETTLE_US) × N cycles after `arb_internal_o`.
- R7: No output, once high, falls until `rst_n` is asserted. In particular `bus_ready_o` stays high indefinitely.
- R8: A start pulse that arrives while a sequence is running, or after ready, has no effect on any output.
- R9: N is the value of `cyc_per_us_i` at the edge where start is accepted. Later changes of that input do not alter the running sequence.
- R10: A captured `cyc_per_us_i` of zero is treated as N = 1.
- R11: The outputs obey a strict chain. The clock enable implies both output enables. Reset release implies the clock enable. Arbiter select implies reset release. Ready implies arbiter select.
- R12: The sequencer state register is one-hot in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| cyc_per_us_i | input | US_W | Core clock cycles per microsecond (0 acts as 1) |
| pci_rst_oe_o | output | 1 | Output enable for the bus reset driver |
| pci_clk_oe_o | output | 1 | Output enable for the bus clock driver |
| pci_clk_en_o | output | 1 | Bus clock running |
| pci_rst_release_o | output | 1 | Bus reset deasserted (high = released) |
| arb_internal_o | output | 1 | Internal bus arbiter selected |
| bus_ready_o | output | 1 | Bring-up complete, bus usable |

## Verification
The checker checks the following every cycle:
- the output ordering chain;
- the one-hot state;
- the fact that no output ever drops;
- that a start during a run never re-enters the driver-enable step;
- the exact hold and settle lengths, measured with its own counters against the captured rate.

Some behaviours only the bench scenarios can show, because each needs a chosen stimulus and a comparison over a whole run:
- a zero rate acting as one;
- a rate change in mid-run being ignored;
- a reset that aborts a hold and is followed by a clean restart at a different rate;
- ready persisting after a late start pulse.

// File: rtl/pcib_seq_pkg.sv
package pcib_seq_pkg;

  typedef enum logic [7:0] {
    ST_IDLE    = 8'b0000_0001,
    ST_OE      = 8'b0000_0010,
    ST_CLK_ON  = 8'b0000_0100,
    ST_HOLD    = 8'b0000_1000,
    ST_RELEASE = 8'b0001_0000,
    ST_ARB     = 8'b0010_0000,
    ST_SETTLE  = 8'b0100_0000,
    ST_READY   = 8'b1000_0000
  } seq_state_e;

  typedef struct packed {
    logic rst_oe;
    logic clk_oe;
    logic clk_en;
    logic rst_rel;
    logic arb_int;
    logic ready;
  } bus_ctl_t;

  // Output pattern for each step; every step keeps the bits of the one before.
  function automatic bus_ctl_t ctl_for_state(seq_state_e s);
    bus_ctl_t c;
    c = '0;
    case (s)
      ST_OE: begin
        c.rst_oe = 1'b1; c.clk_oe = 1'b1;
      end
      ST_CLK_ON, ST_HOLD: begin
        c.rst_oe = 1'b1; c.clk_oe = 1'b1; c.clk_en = 1'b1;
      end
      ST_RELEASE: begin
        c.rst_oe = 1'b1; c.clk_oe = 1'b1; c.clk_en = 1'b1; c.rst_rel = 1'b1;
      end
      ST_ARB, ST_SETTLE: begin
        c.rst_oe = 1'b1; c.clk_oe = 1'b1; c.clk_en = 1'b1; c.rst_rel = 1'b1;
        c.arb_int = 1'b1;
      end
      ST_READY: begin
        c = '1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pcib_rate_latch.sv
module pcib_rate_latch #(
  parameter int US_W      = 8,
  parameter int HOLD_US   = 150,
  parameter int ARB_US    = 1,
  parameter int SETTLE_US = 10000,
  parameter int CNT_W     = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [US_W-1:0]  cyc_per_us_i,
  output logic [CNT_W-1:0] hold_len_o,
  output logic [CNT_W-1:0] arb_len_o,
  output logic [CNT_W-1:0] settle_len_o
);

  localparam logic [US_W-1:0]  ONE_US   = US_W'(1);
  localparam logic [CNT_W-1:0] HOLD_K   = CNT_W'(HOLD_US);
  localparam logic [CNT_W-1:0] ARB_K    = CNT_W'(ARB_US);
  localparam logic [CNT_W-1:0] SETTLE_K = CNT_W'(SETTLE_US);

  logic [US_W-1:0]  rate_q;
  logic [US_W-1:0]  rate_d;
  logic [CNT_W-1:0] rate_ext;

  always_comb begin
    rate_d = (cyc_per_us_i == '0) ? ONE_US : cyc_per_us_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= ONE_US;
    end else if (capture_i) begin
      rate_q <= rate_d;
    end
  end

  always_comb begin
    rate_ext     = {{(CNT_W-US_W){1'b0}}, rate_q};
    hold_len_o   = rate_ext * HOLD_K;
    arb_len_o    = rate_ext * ARB_K;
    settle_len_o = rate_ext * SETTLE_K;
  end

endmodule

// File: rtl/pcib_wait_timer.sv
module pcib_wait_timer #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (|cnt_q);
    cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pcib_seq_fsm.sv
module pcib_seq_fsm
  import pcib_seq_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wait_done_i,
  input  logic [CNT_W-1:0] hold_len_i,
  input  logic [CNT_W-1:0] arb_len_i,
  input  logic [CNT_W-1:0] settle_len_i,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [7:0]       state_o,
  output bus_ctl_t         ctl_o
);

  seq_state_e state_q;
  seq_state_e state_d;
  bus_ctl_t   ctl_q;
  logic       advance;

  // Next-state logic. Each wait loads length-1 so that a wait state lasts
  // exactly its length; the hold state follows the one-cycle clock-on state,
  // so it loads length-2 to make the whole clock-on-in-reset span exact.
  always_comb begin
    state_d    = state_q;
    capture_o  = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_OE;
          capture_o = 1'b1;
        end
      end
      ST_OE: begin
        state_d = ST_CLK_ON;
      end
      ST_CLK_ON: begin
        state_d    = ST_HOLD;
        load_o     = 1'b1;
        load_val_o = hold_len_i - CNT_W'(2);
      end
      ST_HOLD: begin
        if (wait_done_i) begin
          state_d = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        state_d    = ST_ARB;
        load_o     = 1'b1;
        load_val_o = arb_len_i - CNT_W'(1);
      end
      ST_ARB: begin
        if (wait_done_i) begin
          state_d    = ST_SETTLE;
          load_o     = 1'b1;
          load_val_o = settle_len_i - CNT_W'(1);
        end
      end
      ST_SETTLE: begin
        if (wait_done_i) begin
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        state_d = ST_READY;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign advance = (state_d != state_q);

  // State and pad-facing control flops share one enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
    end else if (advance) begin
      state_q <= state_d;
      ctl_q   <= ctl_for_state(state_d);
    end
  end

  assign state_o = state_q;
  assign ctl_o   = ctl_q;

endmodule

// File: rtl/pcib_bringup_seq.sv
module pcib_bringup_seq
  import pcib_seq_pkg::*;
#(
  parameter int US_W      = 8,
  parameter int HOLD_US   = 150,
  parameter int ARB_US    = 1,
  parameter int SETTLE_US = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [US_W-1:0] cyc_per_us_i,
  output logic            pci_rst_oe_o,
  output logic            pci_clk_oe_o,
  output logic            pci_clk_en_o,
  output logic            pci_rst_release_o,
  output logic            arb_internal_o,
  output logic            bus_ready_o
);

  localparam int MAX_US = (SETTLE_US > HOLD_US) ?
                          ((SETTLE_US > ARB_US) ? SETTLE_US : ARB_US) :
                          ((HOLD_US > ARB_US) ? HOLD_US : ARB_US);
  localparam int CNT_W  = $clog2(MAX_US * (2 ** US_W) + 1);

  logic             capture;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             wait_done;
  logic [CNT_W-1:0] hold_len;
  logic [CNT_W-1:0] arb_len;
  logic [CNT_W-1:0] settle_len;
  logic [7:0]       seq_state;
  bus_ctl_t         ctl;

  pcib_rate_latch #(
    .US_W(US_W), .HOLD_US(HOLD_US), .ARB_US(ARB_US),
    .SETTLE_US(SETTLE_US), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .capture_i(capture),
    .cyc_per_us_i(cyc_per_us_i), .hold_len_o(hold_len),
    .arb_len_o(arb_len), .settle_len_o(settle_len)
  );

  pcib_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .load_val_i(load_val), .done_o(wait_done)
  );

  pcib_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .wait_done_i(wait_done), .hold_len_i(hold_len),
    .arb_len_i(arb_len), .settle_len_i(settle_len),
    .capture_o(capture), .load_o(load), .load_val_o(load_val),
    .state_o(seq_state), .ctl_o(ctl)
  );

  assign pci_rst_oe_o      = ctl.rst_oe;
  assign pci_clk_oe_o      = ctl.clk_oe;
  assign pci_clk_en_o      = ctl.clk_en;
  assign pci_rst_release_o = ctl.rst_rel;
  assign arb_internal_o    = ctl.arb_int;
  assign bus_ready_o       = ctl.ready;

endmodule

// File: rtl/pcib_bringup_seq_chk.sv
module pcib_bringup_seq_chk #(
  parameter int US_W      = 8,
  parameter int HOLD_US   = 150,
  parameter int ARB_US    = 1,
  parameter int SETTLE_US = 10000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [US_W-1:0] cyc_per_us_i,
  input logic            rst_oe,
  input logic            clk_oe,
  input logic            clk_en,
  input logic            rst_rel,
  input logic            arb_int,
  input logic            ready,
  input logic [7:0]      state_i
);

  logic [31:0] n_chk;
  logic [31:0] hold_cnt;
  logic [31:0] settle_cnt;

  // Independent measurement of the two long windows.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_chk      <= 32'd1;
      hold_cnt   <= '0;
      settle_cnt <= '0;
    end else begin
      if (start_i && state_i[0]) begin
        n_chk <= (cyc_per_us_i == '0) ? 32'd1 : 32'(cyc_per_us_i);
      end
      hold_cnt   <= (clk_en && !rst_rel) ? hold_cnt + 32'd1 : 32'd0;
      settle_cnt <= (arb_int && !ready) ? settle_cnt + 32'd1 : 32'd0;
    end
  end

  assert_state_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_i));

  assert_clk_needs_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (rst_oe && clk_oe));
  assert_release_needs_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rel |-> clk_en);
  assert_arb_needs_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arb_int |-> rst_rel);
  assert_ready_needs_arb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> arb_int);

  assert_oe_clock_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_oe) |-> (clk_oe && !clk_en && !rst_rel));

  assert_clock_after_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(rst_oe) && !rst_rel));

  assert_hold_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel) |-> (hold_cnt == 32'(HOLD_US) * n_chk));

  assert_arb_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_int) |-> $past(rst_rel));

  assert_settle_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (settle_cnt == 32'(ARB_US + SETTLE_US) * n_chk));

  assert_rst_oe_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rst_oe));
  assert_clk_en_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(clk_en));
  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ready));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !state_i[0]) |=> !state_i[1]);

endmodule

bind pcib_bringup_seq pcib_bringup_seq_chk #(
  .US_W(US_W), .HOLD_US(HOLD_US), .ARB_US(ARB_US), .SETTLE_US(SETTLE_US)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cyc_per_us_i(cyc_per_us_i),
  .rst_oe(pci_rst_oe_o), .clk_oe(pci_clk_oe_o), .clk_en(pci_clk_en_o),
  .rst_rel(pci_rst_release_o), .arb_int(arb_internal_o), .ready(bus_ready_o),
  .state_i(seq_state)
);

// File: tb/pcib_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module pcib_bringup_seq_tb_top;

  localparam int US_W      = 8;
  localparam int HOLD_US   = 150;
  localparam int ARB_US    = 1;
  localparam int SETTLE_US = 10000;
  localparam int RUN_US    = 2 + HOLD_US + ARB_US + SETTLE_US;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic [US_W-1:0] cyc_per_us_i;
  logic            pci_rst_oe_o, pci_clk_oe_o, pci_clk_en_o;
  logic            pci_rst_release_o, arb_internal_o, bus_ready_o;

  int checks;
  int failures;
  bit finished;

  // Reference model state
  int edge_n;
  int k_start;
  int n_ref;

  pcib_bringup_seq #(
    .US_W(US_W), .HOLD_US(HOLD_US), .ARB_US(ARB_US), .SETTLE_US(SETTLE_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cyc_per_us_i(cyc_per_us_i),
    .pci_rst_oe_o(pci_rst_oe_o), .pci_clk_oe_o(pci_clk_oe_o),
    .pci_clk_en_o(pci_clk_en_o), .pci_rst_release_o(pci_rst_release_o),
    .arb_internal_o(arb_internal_o), .bus_ready_o(bus_ready_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural model: remember the accepting edge and the rate; derive
  // every output from elapsed edges.
  initial begin
    edge_n  = 0;
    k_start = -1;
    n_ref   = 1;
  end

  always @(posedge clk) begin
    edge_n = edge_n + 1;
    if (!rst_n) begin
      k_start = -1;
    end else if (k_start < 0 && start_i) begin
      k_start = edge_n;
      n_ref   = (cyc_per_us_i == 0) ? 1 : int'(cyc_per_us_i);
    end
  end

  function automatic logic [5:0] model_ctl();
    int e, h, a, s;
    logic [5:0] r;
    r = '0;
    if (rst_n && k_start >= 0) begin
      e = edge_n - k_start;
      h = HOLD_US * n_ref;
      a = ARB_US * n_ref;
      s = SETTLE_US * n_ref;
      r[5] = (e >= 0);
      r[4] = (e >= 0);
      r[3] = (e >= 1);
      r[2] = (e >= 1 + h);
      r[1] = (e >= 2 + h);
      r[0] = (e >= 2 + h + a + s);
    end
    return r;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at edge %0d", tag, act, exp, edge_n);
    end
  endtask

  task automatic expect_all(input string tag);
    logic [5:0] m;
    m = model_ctl();
    check_bit({tag, " rst_oe"}, pci_rst_oe_o, m[5]);
    check_bit({tag, " clk_oe"}, pci_clk_oe_o, m[4]);
    check_bit({tag, " clk_en"}, pci_clk_en_o, m[3]);
    check_bit({tag, " release"}, pci_rst_release_o, m[2]);
    check_bit({tag, " arb"}, arb_internal_o, m[1]);
    check_bit({tag, " ready"}, bus_ready_o, m[0]);
  endtask

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    logic [5:0] m;
    if (!finished) begin
      m = model_ctl();
      check_bit("R2 rst_oe", pci_rst_oe_o, m[5]);
      check_bit("R2 clk_oe", pci_clk_oe_o, m[4]);
      check_bit("R3 clk_en", pci_clk_en_o, m[3]);
      check_bit("R4 release", pci_rst_release_o, m[2]);
      check_bit("R5 arb", arb_internal_o, m[1]);
      check_bit("R6 ready", bus_ready_o, m[0]);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step(1);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired before the scenarios completed");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; cyc_per_us_i = 8'd1;
    step(3);
    rst_n = 1'b1;
    step(4);
    expect_all("R1 idle after reset");

    // Run at N=1; inject a busy start and a rate change during the hold.
    pulse_start();
    step(60);
    cyc_per_us_i = 8'd7;              // R9: must not change this run
    pulse_start();                     // R8: ignored while running
    step(2);
    expect_all("R8 busy start");
    check_bit("R8 release still low", pci_rst_release_o, 1'b0);
    step(RUN_US + 5);
    expect_all("R9 rate held");
    check_bit("R6 ready reached", bus_ready_o, 1'b1);
    step(30);
    pulse_start();                     // R8: ignored after ready
    step(5);
    expect_all("R7 after late start");
    check_bit("R7 ready persists", bus_ready_o, 1'b1);

    // R10: zero rate behaves as one.
    rst_n = 1'b0;
    step(2);
    expect_all("R1 reset drop");
    check_bit("R1 ready cleared", bus_ready_o, 1'b0);
    rst_n = 1'b1;
    cyc_per_us_i = 8'd0;
    step(2);
    pulse_start();
    step(HOLD_US + 1);
    expect_all("R10 zero rate hold edge");
    check_bit("R10 release at N=1", pci_rst_release_o, 1'b1);
    step(RUN_US);
    expect_all("R10 zero rate ready");

    // Abort in hold at N=3, then restart at N=2.
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    cyc_per_us_i = 8'd3;
    step(2);
    pulse_start();
    step(200);
    check_bit("R4 still holding at N=3", pci_rst_release_o, 1'b0);
    rst_n = 1'b0;
    #0.5;
    check_bit("R1 async drop clk_en", pci_clk_en_o, 1'b0);
    check_bit("R1 async drop rst_oe", pci_rst_oe_o, 1'b0);
    step(2);
    rst_n = 1'b1;
    cyc_per_us_i = 8'd2;
    step(3);
    expect_all("R1 idle after abort");
    pulse_start();
    step(2 * HOLD_US);
    check_bit("R4 release not early at N=2", pci_rst_release_o, 1'b0);
    step(1);
    check_bit("R4 release at N=2", pci_rst_release_o, 1'b1);
    step(1);
    check_bit("R5 arb one cycle later", arb_internal_o, 1'b1);
    step(2 * (ARB_US + SETTLE_US) + 5);
    expect_all("R4 N=2 complete");
    check_bit("R6 ready at N=2", bus_ready_o, 1'b1);

    step(3);
    finish_run();
  end

endmodule